// File: doc/BRIEF.md
# Video Memory Arbiter with Address-Qualified CPU Wait

This block places one byte-wide, single-port video memory between a CPU and a display fetch engine. The display side always wins. When the display engine claims its fetch slot in a cycle, it gets the memory port. The CPU is held off through a ready-style wait output only if, in that same cycle, it is reading or writing an address inside the video window. CPU accesses to any other address, and every access made in a cycle with no fetch slot, run with no wait at all.

The display engine raises a request for one cycle in every eight pixel clocks while the beam is in the visible area. It raises no request during retrace, so the CPU runs free then. The ready decision is combinational from the current CPU address, strobes and slot request. A stalled access is simply held by the CPU and completes in the first cycle with no slot. Writes are gated by that grant, so a held write reaches the memory once. CPU read data is registered and changes only after a granted read, so it stays steady while the CPU waits. Two observation outputs expose the window decode and the stall condition.

Top module: `vmem_arb`

## Requirements
- R1: `addrInWindow` is high exactly when `cpuAddr` lies in 0x2000..0x3FFF (0x1FFF and 0x4000 are outside), independent of the strobes and the slot.
- R2: `stall` is high, and `cpuReady` low, in exactly those cycles where `vidReq` is high, `cpuRd` or `cpuWr` is high, and `addrInWindow` is high. The decision is combinational and is visible in the same cycle as the inputs.
- R3: A CPU access outside the window proceeds with `cpuReady` high even in a cycle with `vidReq` high. An out-of-window write never changes the video memory.
- R4: With `vidReq` low, `cpuReady` is high. A stalled access, held unchanged, sees `cpuReady` go high in the first cycle in which `vidReq` is low, and it completes at the clock edge that ends that cycle.
- R5: A CPU write that is inside the window and granted stores `cpuWdata` at memory offset `cpuAddr` - 0x2000 at the clock edge that ends the granted cycle. While the write is stalled the memory keeps its old byte, and display fetches of that offset return the old byte.
- R6: `cpuRdata` takes the byte at offset `cpuAddr` - 0x2000 at the clock edge that ends a granted in-window read cycle. In every other cycle it holds its value. This covers stalled cycles, out-of-window reads, writes and idle cycles.
- R7: At the clock edge that ends a cycle with `vidReq` high, `vidData` takes the byte at offset `vidAddr`. This happens whatever the CPU is doing in that cycle. `vidData` holds its value when `vidReq` is low.
- R8: While `rst_n` is low, `cpuRdata` and `vidData` read 0x00. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the CPU side, the display side and the memory |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| cpuAddr | input | 16 | CPU byte address |
| cpuRd | input | 1 | CPU read strobe |
| cpuWr | input | 1 | CPU write strobe |
| cpuWdata | input | 8 | CPU write byte |
| cpuRdata | output | 8 | Registered CPU read byte, held while stalled |
| cpuReady | output | 1 | High when the CPU access may complete this cycle |
| vidReq | input | 1 | Display fetch slot request |
| vidAddr | input | 13 | Display fetch offset within the video memory |
| vidData | output | 8 | Registered display fetch byte |
| addrInWindow | output | 1 | CPU address decodes into the video window |
| stall | output | 1 | Display slot collides with a CPU window access |

## Verification
The case that matters is a display fetch slot that lands in the same cycle as a CPU read or write to the video window. The bench provokes it by holding `vidReq` high across a CPU window access for one or more cycles, and also near the window edges and with out-of-window addresses. It judges the collision on several points. `cpuReady` must be low in exactly those cycles. The fetch must return the byte that was in memory before the held write, and `cpuRdata` must stay frozen. When the slot drops, the held access must complete in that first free cycle, and a later fetch or read-back must show its effect.

// File: rtl/vmem_arb_pkg.sv
package vmem_arb_pkg;

  // Strobes issued by the control module to the datapath each cycle.
  typedef struct packed {
    logic ramWe;    // commit CPU write byte
    logic cpuLoad;  // capture memory byte into the CPU read register
    logic vidLoad;  // port belongs to the display fetch this cycle
  } strobe_t;

endpackage

// File: rtl/vmem_arb_ctrl.sv
module vmem_arb_ctrl
  import vmem_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MEM_AW = 13,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h2000
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic              vidReq,
  output logic [MEM_AW-1:0] cpuOff,
  output logic              inWin,
  output logic              collide,
  output strobe_t           strobe
);

  localparam int TAG_W = ADDR_W - MEM_AW;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:MEM_AW];

  logic cpuAct;
  logic grant;

  // Window is one aligned block of 2**MEM_AW bytes: compare upper bits only.
  always_comb begin
    inWin   = (cpuAddr[ADDR_W-1:MEM_AW] == WIN_TAG);
    cpuOff  = cpuAddr[MEM_AW-1:0];
    cpuAct  = cpuRd | cpuWr;
    collide = vidReq & inWin & cpuAct;
    grant   = inWin & ~vidReq;
  end

  always_comb begin
    strobe.vidLoad = vidReq;
    strobe.ramWe   = grant & cpuWr;
    strobe.cpuLoad = grant & cpuRd & ~cpuWr;
  end

endmodule

// File: rtl/vmem_arb_dp.sv
module vmem_arb_dp
  import vmem_arb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MEM_AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobe,
  input  logic [MEM_AW-1:0] cpuOff,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [MEM_AW-1:0] vidAddr,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [DATA_W-1:0] vidData
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [MEM_AW-1:0] portAddr;
  logic [DATA_W-1:0] portQ;

  // Single port: display fetch owns the address whenever it asks.
  always_comb begin
    portAddr = strobe.vidLoad ? vidAddr : cpuOff;
    portQ    = mem[portAddr];
  end

  always_ff @(posedge clk) begin
    if (strobe.ramWe) mem[cpuOff] <= cpuWdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpuRdata <= '0;
      vidData  <= '0;
    end else begin
      if (strobe.vidLoad) vidData  <= portQ;
      if (strobe.cpuLoad) cpuRdata <= portQ;
    end
  end

endmodule

// File: rtl/vmem_arb.sv
module vmem_arb
  import vmem_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 13,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  input  logic              vidReq,
  input  logic [MEM_AW-1:0] vidAddr,
  output logic [DATA_W-1:0] vidData,
  output logic              addrInWindow,
  output logic              stall
);

  strobe_t           strobe;
  logic [MEM_AW-1:0] cpuOff;

  vmem_arb_ctrl #(
    .ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .WIN_BASE(WIN_BASE)
  ) u_ctrl (
    .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr), .vidReq(vidReq),
    .cpuOff(cpuOff), .inWin(addrInWindow), .collide(stall), .strobe(strobe)
  );

  vmem_arb_dp #(
    .DATA_W(DATA_W), .MEM_AW(MEM_AW)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cpuOff(cpuOff),
    .cpuWdata(cpuWdata), .vidAddr(vidAddr),
    .cpuRdata(cpuRdata), .vidData(vidData)
  );

  assign cpuReady = ~stall;

endmodule

// File: rtl/vmem_arb_chk.sv
module vmem_arb_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpuRd,
  input logic              cpuWr,
  input logic              cpuReady,
  input logic              vidReq,
  input logic              addrInWindow,
  input logic              ramWe,
  input logic [DATA_W-1:0] cpuRdata,
  input logic [DATA_W-1:0] vidData
);

  // R3: outside the window the CPU never waits
  a_r3_outside_free: assert property (@(posedge clk) disable iff (!rst_n)
    !addrInWindow |-> cpuReady);

  // R4: no display slot means no wait
  a_r4_noslot_free: assert property (@(posedge clk) disable iff (!rst_n)
    !vidReq |-> cpuReady);

  // R2: a window access colliding with a slot must wait
  a_r2_collide_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (vidReq && addrInWindow && (cpuRd || cpuWr)) |-> !cpuReady);

  // R5: memory write only in a granted cycle, never with a slot present
  a_r5_write_granted: assert property (@(posedge clk) disable iff (!rst_n)
    ramWe |-> (cpuReady && !vidReq && addrInWindow));

  // R6: read register moves only after a granted in-window read
  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpuRd && !cpuWr && cpuReady && addrInWindow) |=> $stable(cpuRdata));

  // R7: fetch register moves only after a slot
  a_r7_viddata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vidReq |=> $stable(vidData));

endmodule

bind vmem_arb vmem_arb_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpuRd(cpuRd), .cpuWr(cpuWr),
  .cpuReady(cpuReady), .vidReq(vidReq), .addrInWindow(addrInWindow),
  .ramWe(strobe.ramWe), .cpuRdata(cpuRdata), .vidData(vidData)
);

// File: tb/sim_vmem_arb.sv
`timescale 1ns/1ps
module sim_vmem_arb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuRd = 1'b0;
  logic        cpuWr = 1'b0;
  logic [7:0]  cpuWdata = '0;
  logic [7:0]  cpuRdata;
  logic        cpuReady;
  logic        vidReq = 1'b0;
  logic [12:0] vidAddr = '0;
  logic [7:0]  vidData;
  logic        addrInWindow;
  logic        stall;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vmem_arb u0 (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .vidReq(vidReq), .vidAddr(vidAddr), .vidData(vidData),
    .addrInWindow(addrInWindow), .stall(stall)
  );

  // Vector: {vidReq, cpuRd, cpuWr, cpuAddr[15:0], expReady, expStall, expWin}
  localparam int NVEC = 12;
  localparam logic [21:0] VEC [NVEC] = '{
    {3'b010, 16'h1FFF, 3'b100},  // R1 below window, no slot
    {3'b010, 16'h2000, 3'b101},  // R1 first window byte
    {3'b010, 16'h3FFF, 3'b101},  // R1 last window byte
    {3'b010, 16'h4000, 3'b100},  // R1 above window
    {3'b110, 16'h2000, 3'b011},  // R2 collide at low edge
    {3'b110, 16'h3FFF, 3'b011},  // R2 collide at high edge
    {3'b110, 16'h1FFF, 3'b100},  // R3 just below, slot present
    {3'b110, 16'h4000, 3'b100},  // R3 just above, slot present
    {3'b100, 16'h2400, 3'b101},  // R2 no strobe: no wait
    {3'b110, 16'h2400, 3'b011},  // R2 frame buffer collide
    {3'b010, 16'h2400, 3'b101},  // R4 no slot, in window
    {3'b110, 16'h0000, 3'b100}   // R3 low memory, slot present
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic v, input logic [12:0] va, input logic rd,
                       input logic wr, input logic [15:0] a, input logic [7:0] d);
    vidReq = v; vidAddr = va; cpuRd = rd; cpuWr = wr; cpuAddr = a; cpuWdata = d;
    #1;
  endtask

  task automatic idle;
    drive(1'b0, '0, 1'b0, 1'b0, 16'h0000, 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 rdata in reset", {8'h0, cpuRdata}, 16'h0000);
    chk("R8 viddata in reset", {8'h0, vidData}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][21], 13'h0, VEC[i][20], VEC[i][19], VEC[i][18:3], 8'h00);
      chk("R1/R2/R3/R4 ready", {15'h0, cpuReady}, {15'h0, VEC[i][2]});
      chk("R2 stall", {15'h0, stall}, {15'h0, VEC[i][1]});
      chk("R1 window", {15'h0, addrInWindow}, {15'h0, VEC[i][0]});
      step();
    end
    idle();
    step();

    // R5: plain writes, no slot
    drive(1'b0, '0, 1'b0, 1'b1, 16'h2400, 8'hA5); step();
    drive(1'b0, '0, 1'b0, 1'b1, 16'h2401, 8'h11); step();
    drive(1'b0, '0, 1'b0, 1'b1, 16'h3FFF, 8'h77); step();
    idle();

    // R6: read back
    drive(1'b0, '0, 1'b1, 1'b0, 16'h2400, 8'h00); step();
    chk("R6 read back", {8'h0, cpuRdata}, 16'h00A5);
    idle(); step();
    chk("R6 hold when idle", {8'h0, cpuRdata}, 16'h00A5);

    // R7: fetches, including the last offset
    drive(1'b1, 13'h1FFF, 1'b0, 1'b0, 16'h0000, 8'h00); step();
    chk("R7 fetch top offset", {8'h0, vidData}, 16'h0077);
    idle(); step();
    chk("R7 hold without slot", {8'h0, vidData}, 16'h0077);

    // R5/R2/R4: stalled write over two slot cycles
    drive(1'b1, 13'h0401, 1'b0, 1'b1, 16'h2401, 8'h3C);
    chk("R2 write stalled", {15'h0, cpuReady}, 16'h0000);
    step();
    chk("R5 old byte seen during stall", {8'h0, vidData}, 16'h0011);
    #1;
    chk("R2 still stalled", {15'h0, cpuReady}, 16'h0000);
    step();
    chk("R5 old byte second slot", {8'h0, vidData}, 16'h0011);
    drive(1'b0, 13'h0401, 1'b0, 1'b1, 16'h2401, 8'h3C);
    chk("R4 ready in first free cycle", {15'h0, cpuReady}, 16'h0001);
    step();
    idle();
    drive(1'b1, 13'h0401, 1'b0, 1'b0, 16'h0000, 8'h00); step();
    chk("R5 write landed once granted", {8'h0, vidData}, 16'h003C);

    // R6/R4: stalled read keeps rdata, completes after slot
    drive(1'b0, '0, 1'b1, 1'b0, 16'h3FFF, 8'h00); step();
    chk("R6 read top", {8'h0, cpuRdata}, 16'h0077);
    drive(1'b1, 13'h0400, 1'b1, 1'b0, 16'h2400, 8'h00);
    chk("R2 read stalled", {15'h0, cpuReady}, 16'h0000);
    step();
    chk("R6 rdata held in stall", {8'h0, cpuRdata}, 16'h0077);
    chk("R7 fetch during contention", {8'h0, vidData}, 16'h00A5);
    drive(1'b0, 13'h0400, 1'b1, 1'b0, 16'h2400, 8'h00);
    chk("R4 read released", {15'h0, cpuReady}, 16'h0001);
    step();
    chk("R4 stalled read completes", {8'h0, cpuRdata}, 16'h00A5);

    // R3/R6: out-of-window read with slot
    drive(1'b1, 13'h0401, 1'b1, 1'b0, 16'h1000, 8'h00);
    chk("R3 outside read free", {15'h0, cpuReady}, 16'h0001);
    step();
    chk("R6 outside read no load", {8'h0, cpuRdata}, 16'h00A5);
    chk("R7 fetch beside outside read", {8'h0, vidData}, 16'h003C);

    // R3: out-of-window writes alias nothing
    drive(1'b0, '0, 1'b0, 1'b1, 16'h0400, 8'hEE); step();
    drive(1'b1, 13'h0400, 1'b0, 1'b1, 16'h4400, 8'hDD);
    chk("R3 outside write with slot free", {15'h0, cpuReady}, 16'h0001);
    step();
    chk("R3 outside writes ignored", {8'h0, vidData}, 16'h00A5);
    idle();

    // R8: reset again clears registers, memory kept
    rst_n = 1'b0; #1;
    chk("R8 rdata cleared", {8'h0, cpuRdata}, 16'h0000);
    chk("R8 viddata cleared", {8'h0, vidData}, 16'h0000);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    drive(1'b1, 13'h0401, 1'b0, 1'b0, 16'h0000, 8'h00); step();
    chk("R8 memory survives reset", {8'h0, vidData}, 16'h003C);
    idle();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule